// File: doc/BRIEF.md
# PAL Field Sync Sequencer

This block paces the vertical interval of one monochrome PAL field. The field is split into half-line phases, and a single phase counter walks through them. Broad (long) sync pulses come first. Pre-equalising short pulses follow. Then a single picture phase hands the screen to an external line renderer. Post-equalising short pulses close the field, and the counter wraps to the first broad pulse.

All timing is counted in ticks of an external 1 us enable. A broad pulse holds sync low (0 V) for 30 ticks and high (black level) for 2 ticks. A short pulse holds sync low for 2 ticks and high for 30 ticks. During the picture phase the sequencer ignores ticks. It keeps sync high, raises busy and waits for the renderer to report completion.

Top module: `pal_field_seq`

## Requirements
- R1: While reset is asserted and just after it, sync_o is 1, busy_o is 0 and pic_start_o is 0. The first us_tick after reset drives sync_o to 0, which starts a broad pulse.
- R2: The field opens with 5 broad pulses. Each holds sync_o at 0 for 30 ticks and then at 1 for 2 ticks.
- R3: 5 short pulses follow the broad pulses. Each holds sync_o at 0 for 2 ticks and then at 1 for 30 ticks.
- R4: On the tick that ends the fifth short pulse, the picture phase begins. In that cycle pic_start_o is 1, busy_o is 1 and sync_o is 1.
- R5: During the picture phase, us_tick has no effect. sync_o stays 1 and busy_o stays 1 until pic_done_i is seen.
- R6: In the cycle after pic_done_i is sampled during the picture phase, busy_o is 0 and sync_o is 0. That first post-picture short pulse stays low for 2 ticks and then high for 30 ticks.
- R7: 6 short pulses follow the picture. The field then wraps: the next pulse is a broad one, 30 ticks low.
- R8: pic_done_i has no effect outside the picture phase. busy_o and sync_o do not change, and the pulse in progress keeps its length.
- R9: Outside the picture phase, sync_o changes only on a cycle with us_tick high. Clock cycles without a tick leave it unchanged.
- R10: pic_start_o is high for exactly one cycle per picture phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle 1 us timing enable |
| pic_done_i | input | 1 | Line renderer has finished the active region |
| sync_o | output | 1 | Composite sync: 0 = sync tip, 1 = black level |
| pic_start_o | output | 1 | One-cycle strobe that starts the line renderer |
| busy_o | output | 1 | High for the whole picture phase |

## Verification
The hardest point to reach from the ports is the wrap from the last post-picture short pulse back to a broad pulse. Getting there takes a complete field: 20 tick-paced phases, a renderer handshake, and 12 more phases. The stimulus drives exact tick counts phase by phase. It checks sync just before and just after each expected edge, and completes the picture phase with a single pic_done_i pulse. After the wrap, the stimulus holds the 30-tick low window. A short pulse would have risen after 2 ticks, so this window shows which kind of pulse followed.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    // Class of a half-line phase, chosen by the range the phase index falls in
    typedef enum logic [2:0] {
        K_LONG      = 3'd0,
        K_SHORT_PRE = 3'd1,
        K_PICTURE   = 3'd2,
        K_SHORT_PST = 3'd3,
        K_INVALID   = 3'd4
    } phase_kind_e;

endpackage

// File: rtl/pfs_phase_decode.sv
module pfs_phase_decode
    import pfs_pkg::*;
#(
    parameter int PW       = 6,
    parameter int N_LONG   = 10,
    parameter int N_PRE    = 10,
    parameter int N_POST   = 12
) (
    input  logic [PW-1:0] phase_i,
    output phase_kind_e   kind_o,
    output logic          low_half_o
);
    localparam logic [PW-1:0] PRE0  = PW'(N_LONG);
    localparam logic [PW-1:0] PIC   = PW'(N_LONG + N_PRE);
    localparam logic [PW-1:0] POST0 = PW'(N_LONG + N_PRE + 1);
    localparam logic [PW-1:0] LAST  = PW'(N_LONG + N_PRE + N_POST);

    logic [PW-1:0] rel;

    always_comb begin
        rel    = '0;
        kind_o = K_INVALID;
        if (phase_i < PRE0) begin
            kind_o = K_LONG;
            rel    = phase_i;
        end else if (phase_i < PIC) begin
            kind_o = K_SHORT_PRE;
            rel    = phase_i - PRE0;
        end else if (phase_i == PIC) begin
            kind_o = K_PICTURE;
        end else if (phase_i <= LAST) begin
            kind_o = K_SHORT_PST;
            rel    = phase_i - POST0;
        end
        // even offset inside a group = the sync-low half of a pulse
        low_half_o = ~rel[0];
    end
endmodule

// File: rtl/pfs_tick_timer.sv
module pfs_tick_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expire_o,
    output logic          idle_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (tick_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign idle_o   = (cnt_q == '0);
    assign expire_o = tick_i && (cnt_q == CW'(1));
endmodule

// File: rtl/pal_field_seq.sv
module pal_field_seq
    import pfs_pkg::*;
#(
    parameter int LONG_TICKS  = 30,
    parameter int SHORT_TICKS = 2,
    parameter int LONG_PULSES = 5,
    parameter int PRE_PULSES  = 5,
    parameter int POST_PULSES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic us_tick,
    input  logic pic_done_i,
    output logic sync_o,
    output logic pic_start_o,
    output logic busy_o
);
    localparam int N_LONG  = 2 * LONG_PULSES;
    localparam int N_PRE   = 2 * PRE_PULSES;
    localparam int N_POST  = 2 * POST_PULSES;
    localparam int LAST_I  = N_LONG + N_PRE + N_POST;
    localparam int PW      = $clog2(LAST_I + 1);
    localparam int CW      = $clog2(LONG_TICKS + 1);
    localparam logic [PW-1:0] PIC_P  = PW'(N_LONG + N_PRE);
    localparam logic [PW-1:0] LAST_P = PW'(LAST_I);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_TICKS);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_TICKS);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          sync;
        logic          busy;
        logic          start;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expire;
    logic          tmr_idle;

    logic [PW-1:0] tgt_phase;
    logic [PW-1:0] nxt_phase;
    phase_kind_e   tgt_kind;
    logic          tgt_low;
    logic          do_enter;

    pfs_tick_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (us_tick),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expire_o   (tmr_expire),
        .idle_o     (tmr_idle)
    );

    pfs_phase_decode #(
        .PW     (PW),
        .N_LONG (N_LONG),
        .N_PRE  (N_PRE),
        .N_POST (N_POST)
    ) u_dec (
        .phase_i    (tgt_phase),
        .kind_o     (tgt_kind),
        .low_half_o (tgt_low)
    );

    assign nxt_phase = (seq_q.phase >= LAST_P) ? '0 : seq_q.phase + 1'b1;

    // choose which phase (if any) is entered this cycle
    always_comb begin
        tgt_phase = seq_q.phase;
        do_enter  = 1'b0;
        if (seq_q.phase == PIC_P) begin
            if (pic_done_i) begin
                tgt_phase = nxt_phase;
                do_enter  = 1'b1;
            end
        end else if (seq_q.phase > LAST_P) begin
            tgt_phase = '0;
        end else if (us_tick && tmr_idle) begin
            do_enter  = 1'b1;
        end else if (tmr_expire) begin
            tgt_phase = nxt_phase;
            do_enter  = 1'b1;
        end
    end

    // next-state of the sequencer and timer reload
    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        if (seq_q.phase > LAST_P) begin
            seq_d.phase = '0;
            seq_d.sync  = 1'b1;
            seq_d.busy  = 1'b0;
            tmr_load    = 1'b1;
        end else if (do_enter) begin
            seq_d.phase = tgt_phase;
            tmr_load    = 1'b1;
            unique case (tgt_kind)
                K_PICTURE: begin
                    seq_d.sync  = 1'b1;
                    seq_d.busy  = 1'b1;
                    seq_d.start = 1'b1;
                    tmr_val     = '0;
                end
                K_LONG: begin
                    seq_d.sync = ~tgt_low;
                    seq_d.busy = 1'b0;
                    tmr_val    = tgt_low ? LONG_V : SHORT_V;
                end
                K_SHORT_PRE, K_SHORT_PST: begin
                    seq_d.sync = ~tgt_low;
                    seq_d.busy = 1'b0;
                    tmr_val    = tgt_low ? SHORT_V : LONG_V;
                end
                default: begin
                    seq_d.phase = '0;
                    seq_d.sync  = 1'b1;
                    seq_d.busy  = 1'b0;
                    tmr_val     = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '{phase: '0, sync: 1'b1, busy: 1'b0, start: 1'b0};
        else     seq_q <= seq_d;
    end

    assign sync_o      = seq_q.sync;
    assign busy_o      = seq_q.busy;
    assign pic_start_o = seq_q.start;
endmodule

// File: rtl/pfs_field_chk.sv
module pfs_field_chk #(
    parameter int LONG_TICKS  = 30,
    parameter int SHORT_TICKS = 2
) (
    input logic clk,
    input logic rst,
    input logic us_tick,
    input logic pic_done_i,
    input logic sync_o,
    input logic pic_start_o,
    input logic busy_o
);
    localparam int LW = $clog2(LONG_TICKS + 2);

    logic [LW-1:0] low_ticks;

    always_ff @(posedge clk) begin
        if (rst || sync_o) low_ticks <= '0;
        else if (us_tick)  low_ticks <= low_ticks + 1'b1;
    end

    // R2 R3 R6
    low_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_o) |-> (low_ticks == LW'(LONG_TICKS) || low_ticks == LW'(SHORT_TICKS)));

    // R10
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pic_start_o |=> !pic_start_o);

    // R4
    pic_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (pic_start_o && sync_o));

    // R5
    pic_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !pic_done_i) |=> (busy_o && sync_o));

    // R6
    pic_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (!sync_o && $past(pic_done_i)));

    // R9
    tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!us_tick && !pic_done_i) |=> $stable(sync_o));

    // R8
    done_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (pic_done_i && !busy_o && !us_tick) |=> (!busy_o && $stable(sync_o)));
endmodule

bind pal_field_seq pfs_field_chk #(
    .LONG_TICKS  (LONG_TICKS),
    .SHORT_TICKS (SHORT_TICKS)
) u_field_chk (
    .clk         (clk),
    .rst         (rst),
    .us_tick     (us_tick),
    .pic_done_i  (pic_done_i),
    .sync_o      (sync_o),
    .pic_start_o (pic_start_o),
    .busy_o      (busy_o)
);

// File: tb/tb_pal_field_seq.sv
module tb_pal_field_seq;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic us_tick = 1'b0;
    logic pic_done_i = 1'b0;
    logic sync_o, pic_start_o, busy_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pal_field_seq dut (
        .clk         (clk),
        .rst         (rst),
        .us_tick     (us_tick),
        .pic_done_i  (pic_done_i),
        .sync_o      (sync_o),
        .pic_start_o (pic_start_o),
        .busy_o      (busy_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) us_tick = 1'b1;
            @(negedge clk) us_tick = 1'b0;
        end
    endtask

    task automatic done_pulse();
        @(negedge clk) pic_done_i = 1'b1;
        @(negedge clk) pic_done_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 sync in reset", sync_o, 1'b1);
        chk("R1 busy in reset", busy_o, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sync after reset", sync_o, 1'b1);
        chk("R1 start after reset", pic_start_o, 1'b0);
        repeat (5) @(negedge clk);
        chk("R9 no tick keeps sync", sync_o, 1'b1);
        do_ticks(1);
        chk("R1 first tick starts broad pulse", sync_o, 1'b0);
    endtask

    task automatic t_long();
        for (int p = 0; p < 5; p++) begin
            if (p == 0) begin
                do_ticks(10);
                done_pulse();
                chk("R8 done ignored busy", busy_o, 1'b0);
                chk("R8 done ignored sync", sync_o, 1'b0);
                repeat (4) @(negedge clk);
                chk("R9 idle clocks keep low", sync_o, 1'b0);
                do_ticks(19);
            end else begin
                do_ticks(29);
            end
            chk("R2 low held 29 ticks", sync_o, 1'b0);
            do_ticks(1);
            chk("R2 high after 30 ticks", sync_o, 1'b1);
            do_ticks(1);
            chk("R2 high mid gap", sync_o, 1'b1);
            do_ticks(1);
            chk("R2 low after 2-tick gap", sync_o, 1'b0);
        end
    endtask

    task automatic t_pre_short();
        for (int p = 0; p < 5; p++) begin
            do_ticks(1);
            chk("R3 short low first tick", sync_o, 1'b0);
            do_ticks(1);
            chk("R3 short high after 2", sync_o, 1'b1);
            do_ticks(29);
            chk("R3 short high held", sync_o, 1'b1);
            chk("R3 no early picture", busy_o, 1'b0);
            do_ticks(1);
            if (p < 4) begin
                chk("R3 next short low", sync_o, 1'b0);
            end else begin
                chk("R4 start strobe", pic_start_o, 1'b1);
                chk("R4 busy raised", busy_o, 1'b1);
                chk("R4 sync high", sync_o, 1'b1);
                @(negedge clk);
                chk("R10 start one cycle", pic_start_o, 1'b0);
            end
        end
    endtask

    task automatic t_picture_hold();
        do_ticks(40);
        chk("R5 sync held", sync_o, 1'b1);
        chk("R5 busy held", busy_o, 1'b1);
        chk("R10 no second strobe", pic_start_o, 1'b0);
    endtask

    task automatic t_post_and_wrap();
        done_pulse();
        chk("R6 busy drops", busy_o, 1'b0);
        chk("R6 sync low at once", sync_o, 1'b0);
        for (int p = 0; p < 6; p++) begin
            do_ticks(1);
            chk("R6 post low first tick", sync_o, 1'b0);
            do_ticks(1);
            chk("R6 post high after 2", sync_o, 1'b1);
            do_ticks(29);
            chk("R7 post high held", sync_o, 1'b1);
            do_ticks(1);
            chk("R7 next pulse low", sync_o, 1'b0);
        end
        do_ticks(29);
        chk("R7 wrapped to broad low", sync_o, 1'b0);
        do_ticks(1);
        chk("R7 broad rises at 30", sync_o, 1'b1);
        chk("R7 busy low after wrap", busy_o, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_long();
        t_pre_short();
        t_picture_hold();
        t_post_and_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule